// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block feeds a DMA channel from a chain of descriptors kept in memory. Each descriptor holds four words: source address, destination address, length, and the address of the next descriptor. A start pulse makes the block capture the head pointer and read the first descriptor one word at a time. It then presents the three transfer fields to the channel with a one-cycle load strobe and waits for the transfer engine to report completion.

On completion the block follows the stored next pointer and fetches again. Software normally closes the chain into a ring, so the last descriptor points back at the head. The block marks each pass around the ring with a list-done pulse. An optional redirect rule lets a chosen next-pointer value be replaced by a programmed restart address. A halt level, sampled at completion, ends the walk.

Top module: `lldesc_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_req`, `load_stb` and `list_done` are all low.
- R2: A `start` pulse while idle captures `head_ptr` as both the fetch pointer and the ring head, and `rd_req` rises in the next cycle. A `start` while busy is ignored, and so is a change of `head_ptr` while busy.
- R3: A descriptor is read as four single-beat reads at pointer+0, +4, +8 and +12 (byte addresses, 32-bit words). The words are, in that order, source, destination, length and next pointer. A new read is requested only after the data of the previous one has returned on `rd_valid`.
- R4: `load_stb` is high for exactly one cycle, in the cycle after the fourth word arrives. The source, destination and length of that descriptor are on `load_src`, `load_dst` and `load_len`.
- R5: `xfer_done` while a transfer is running and `halt` is low starts the fetch of the descriptor named by the next pointer, with `rd_req` high in the following cycle. `xfer_done` at any other time has no effect.
- R6: `xfer_done` with `halt` high returns the block to idle, and no further reads are issued.
- R7: `list_done` is a one-cycle pulse, in the cycle after an accepted `xfer_done`, when the finished descriptor's next pointer equals the captured ring head.
- R8: When `wrap_en` is high and a followed next pointer equals `wrap_at`, the next fetch uses `restart_at` instead. With `wrap_en` low the next pointer is used unchanged.
- R9: `busy` is high from the cycle after an accepted start until the block returns to idle. No read is requested while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin walking the chain at head_ptr |
| head_ptr | input | AW | Address of the first descriptor |
| halt | input | 1 | Stop after the transfer that is ending |
| wrap_en | input | 1 | Enable next-pointer redirect |
| wrap_at | input | AW | Next-pointer value that triggers the redirect |
| restart_at | input | AW | Address fetched in place of wrap_at |
| rd_req | output | 1 | Single-beat read request |
| rd_addr | output | AW | Read byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DW | Read data |
| load_stb | output | 1 | One-cycle channel register load |
| load_src | output | AW | Source address of the loaded descriptor |
| load_dst | output | AW | Destination address of the loaded descriptor |
| load_len | output | DW | Length of the loaded descriptor |
| xfer_done | input | 1 | Transfer of the loaded descriptor finished |
| list_done | output | 1 | Ring pass completed |
| busy | output | 1 | Walk in progress |

## Verification
The walk is exercised on four kinds of chain:
- A three-entry ring with one-cycle memory latency. This separates correct next-pointer following from replaying one descriptor, and it shows that list-done fires only on the entry that closes the ring.
- A single self-linked entry with three-cycle latency. This checks that a read waits for late data, and that list-done fires on every pass.
- A chain whose next pointer hits the redirect value. Here fields from the wrong descriptor would show at once, because a decoy descriptor sits at the redirect address.
- A stray completion while idle, and a second start during a walk. These show that such inputs are ignored.

Field order is checked through the loaded values, because each word of every descriptor is distinct.

// File: rtl/lldw_pkg.sv
package lldw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_RUN   = 2'd3
  } walk_state_t;

  localparam int DESC_WORDS = 4;
  localparam int W_SRC  = 0;
  localparam int W_DST  = 1;
  localparam int W_LEN  = 2;
  localparam int W_NEXT = 3;
endpackage

// File: rtl/lldw_addr_gen.sv
module lldw_addr_gen
  import lldw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_take,
  input  logic            beat_take,
  input  logic            follow,
  input  logic [AW-1:0]   head_ptr,
  input  logic [AW-1:0]   next_ptr,
  input  logic            wrap_en,
  input  logic [AW-1:0]   wrap_at,
  input  logic [AW-1:0]   restart_at,
  output logic [AW-1:0]   rd_addr,
  output logic [IDXW-1:0] word_idx,
  output logic            last_word,
  output logic            ring_closed
);
  localparam int WORD_BYTES = DW / 8;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 1);

  // Byte address of one word inside a descriptor.
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                               input logic [IDXW-1:0] idx);
    return base + AW'(idx) * AW'(WORD_BYTES);
  endfunction

  // Where the walk goes after a descriptor finishes.
  function automatic logic [AW-1:0] follow_ptr(input logic [AW-1:0] nxt,
                                                input logic en,
                                                input logic [AW-1:0] at,
                                                input logic [AW-1:0] rst_to);
    return (en && (nxt == at)) ? rst_to : nxt;
  endfunction

  logic [AW-1:0] cur_ptr;
  logic [AW-1:0] head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr  <= '0;
      head_q   <= '0;
      word_idx <= '0;
    end else if (start_take) begin
      cur_ptr  <= head_ptr;
      head_q   <= head_ptr;
      word_idx <= '0;
    end else if (follow) begin
      cur_ptr  <= follow_ptr(next_ptr, wrap_en, wrap_at, restart_at);
      word_idx <= '0;
    end else if (beat_take) begin
      word_idx <= last_word ? '0 : word_idx + 1'b1;
    end
  end

  assign rd_addr     = word_addr(cur_ptr, word_idx);
  assign last_word   = (word_idx == LAST_IDX);
  assign ring_closed = (next_ptr == head_q);
endmodule

// File: rtl/lldw_desc_buf.sv
module lldw_desc_buf
  import lldw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_take,
  input  logic [IDXW-1:0] word_idx,
  input  logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   src_addr,
  output logic [AW-1:0]   dst_addr,
  output logic [DW-1:0]   xfer_len,
  output logic [AW-1:0]   next_ptr
);
  logic [DW-1:0] words [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (beat_take && (word_idx == IDXW'(g)))
        words[g] <= rd_data;
    end
  end

  assign src_addr = AW'(words[W_SRC]);
  assign dst_addr = AW'(words[W_DST]);
  assign xfer_len = words[W_LEN];
  assign next_ptr = AW'(words[W_NEXT]);
endmodule

// File: rtl/lldw_ctrl.sv
module lldw_ctrl
  import lldw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_valid,
  input  logic xfer_done,
  input  logic halt,
  input  logic last_word,
  input  logic ring_closed,
  output logic start_take,
  output logic beat_take,
  output logic done_take,
  output logic follow,
  output logic rd_req,
  output logic load_stb,
  output logic list_done,
  output logic busy
);
  walk_state_t st;
  logic        pend;

  assign start_take = (st == ST_IDLE) && start;
  assign beat_take  = (st == ST_FETCH) && pend && rd_valid;
  assign done_take  = (st == ST_RUN) && xfer_done;
  assign follow     = done_take && !halt;
  assign rd_req     = (st == ST_FETCH) && !pend;
  assign load_stb   = (st == ST_LOAD);
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      list_done <= 1'b0;
    end else begin
      list_done <= done_take && ring_closed;
      if (rd_req)
        pend <= 1'b1;
      else if (beat_take)
        pend <= 1'b0;
      unique case (st)
        ST_IDLE:  if (start_take) st <= ST_FETCH;
        ST_FETCH: if (beat_take && last_word) st <= ST_LOAD;
        ST_LOAD:  st <= ST_RUN;
        ST_RUN:   if (done_take) st <= halt ? ST_IDLE : ST_FETCH;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lldesc_walker.sv
module lldesc_walker
  import lldw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] head_ptr,
  input  logic          halt,
  input  logic          wrap_en,
  input  logic [AW-1:0] wrap_at,
  input  logic [AW-1:0] restart_at,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          load_stb,
  output logic [AW-1:0] load_src,
  output logic [AW-1:0] load_dst,
  output logic [DW-1:0] load_len,
  input  logic          xfer_done,
  output logic          list_done,
  output logic          busy
);
  localparam int IDXW = $clog2(DESC_WORDS);

  // Internal events, named for the checker.
  logic            start_take;
  logic            beat_take;
  logic            done_take;
  logic            follow;
  logic            last_word;
  logic            ring_closed;
  logic [IDXW-1:0] word_idx;
  logic [AW-1:0]   next_ptr;

  lldw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_valid   (rd_valid),
    .xfer_done  (xfer_done),
    .halt       (halt),
    .last_word  (last_word),
    .ring_closed(ring_closed),
    .start_take (start_take),
    .beat_take  (beat_take),
    .done_take  (done_take),
    .follow     (follow),
    .rd_req     (rd_req),
    .load_stb   (load_stb),
    .list_done  (list_done),
    .busy       (busy)
  );

  lldw_addr_gen #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_take (start_take),
    .beat_take  (beat_take),
    .follow     (follow),
    .head_ptr   (head_ptr),
    .next_ptr   (next_ptr),
    .wrap_en    (wrap_en),
    .wrap_at    (wrap_at),
    .restart_at (restart_at),
    .rd_addr    (rd_addr),
    .word_idx   (word_idx),
    .last_word  (last_word),
    .ring_closed(ring_closed)
  );

  lldw_desc_buf #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_take(beat_take),
    .word_idx (word_idx),
    .rd_data  (rd_data),
    .src_addr (load_src),
    .dst_addr (load_dst),
    .xfer_len (load_len),
    .next_ptr (next_ptr)
  );
endmodule

// File: rtl/lldw_checker.sv
module lldw_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic halt,
  input logic rd_req,
  input logic load_stb,
  input logic list_done,
  input logic beat_take,
  input logic done_take
);
  logic [2:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beats <= '0;
    else if (load_stb)
      beats <= '0;
    else if (beat_take)
      beats <= beats + 1'b1;
  end

  p_fetch_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> rd_req);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_load_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  p_load_after_four_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> (beats == 3'd4));

  p_follow_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_take && !halt) |=> rd_req);

  p_halt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_take && halt) |=> !busy);

  p_list_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> $past(done_take));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
endmodule

bind lldesc_walker lldw_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .halt     (halt),
  .rd_req   (rd_req),
  .load_stb (load_stb),
  .list_done(list_done),
  .beat_take(beat_take),
  .done_take(done_take)
);

// File: tb/lldesc_walker_test.sv
module lldesc_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] head_ptr = '0;
  logic          halt = 1'b0;
  logic          wrap_en = 1'b0;
  logic [AW-1:0] wrap_at = '0;
  logic [AW-1:0] restart_at = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          load_stb;
  logic [AW-1:0] load_src;
  logic [AW-1:0] load_dst;
  logic [DW-1:0] load_len;
  logic          xfer_done = 1'b0;
  logic          list_done;
  logic          busy;

  int checks = 0;
  int fails = 0;
  int mem_lat = 1;
  int run_lat = 3;
  int target = 0;
  int xfer_cnt = 0;
  int loads = 0;
  int ld_seen = 0;
  int reads_since = 0;
  int stray_reads = 0;

  bit [31:0] mem [bit [31:0]];
  logic [95:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lldesc_walker #(.AW(AW), .DW(DW)) uut (.*);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input bit [31:0] base, input bit [31:0] s,
                          input bit [31:0] d, input bit [31:0] l, input bit [31:0] n);
    mem[base] = s; mem[base+4] = d; mem[base+8] = l; mem[base+12] = n;
  endtask

  task automatic push_exp(input bit [31:0] base);
    expq.push_back({mem[base], mem[base+4], mem[base+8]});
  endtask

  // Memory model: one request, data after mem_lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        bit [31:0] a;
        a = rd_addr;
        reads_since++;
        if (!busy) stray_reads++;
        repeat (mem_lat) @(negedge clk);
        rd_data = mem.exists(a) ? mem[a] : 32'hDEAD_0000;
        rd_valid = 1'b1;
      end
    end
  end

  // Transfer engine model.
  initial begin
    forever begin
      @(negedge clk);
      if (load_stb) begin
        repeat (run_lat) @(negedge clk);
        halt = (xfer_cnt == target - 1);
        xfer_done = 1'b1;
        xfer_cnt++;
        @(negedge clk);
        xfer_done = 1'b0;
        halt = 1'b0;
      end
    end
  end

  // Monitor / scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (list_done) ld_seen++;
      if (load_stb) begin
        logic [95:0] e;
        loads++;
        chk("R4 reads before load", 96'(reads_since), 96'd4);
        reads_since = 0;
        if (expq.size() == 0) begin
          chk("R5 unexpected load", {load_src, load_dst, load_len}, 96'h0);
        end else begin
          e = expq.pop_front();
          chk("R3 R4 loaded fields", {load_src, load_dst, load_len}, e);
        end
      end
    end
  end

  task automatic run_chain(input bit [31:0] head, input int lat, input int nloads,
                           input int exp_ld, input bit poke);
    mem_lat = lat; target = nloads; xfer_cnt = 0; loads = 0; ld_seen = 0;
    reads_since = 0;
    @(negedge clk);
    head_ptr = head; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", 96'(busy), 96'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      head_ptr = 32'h0000_0F00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6 loads before halt", 96'(loads), 96'(nloads));
    chk("R7 list_done count", 96'(ld_seen), 96'(exp_ld));
    chk("R4 queue drained", 96'(expq.size()), 96'd0);
    chk("R6 no read after halt", 96'(rd_req), 96'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 96'(busy), 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 96'(busy), 96'd0);
    chk("R1 rd_req", 96'(rd_req), 96'd0);
    chk("R1 load_stb", 96'(load_stb), 96'd0);
    chk("R1 list_done", 96'(list_done), 96'd0);

    // Three-entry ring, fast memory, two passes partly.
    put_desc(32'h100, 32'hA000_0001, 32'hB000_0001, 32'h11, 32'h200);
    put_desc(32'h200, 32'hA000_0002, 32'hB000_0002, 32'h22, 32'h300);
    put_desc(32'h300, 32'hA000_0003, 32'hB000_0003, 32'h33, 32'h100);
    put_desc(32'hF00, 32'hEEEE_0001, 32'hEEEE_0002, 32'hEE, 32'hF00);
    push_exp(32'h100); push_exp(32'h200); push_exp(32'h300);
    push_exp(32'h100); push_exp(32'h200);
    run_chain(32'h100, 1, 5, 1, 1'b0);

    // Self-linked entry, slow memory: R7 fires every pass.
    put_desc(32'h800, 32'hC000_0008, 32'hD000_0008, 32'h88, 32'h800);
    push_exp(32'h800); push_exp(32'h800); push_exp(32'h800);
    run_chain(32'h800, 3, 3, 3, 1'b0);

    // R2: start during a walk is ignored (decoy at 0xF00 never loads).
    push_exp(32'h100); push_exp(32'h200); push_exp(32'h300);
    run_chain(32'h100, 2, 3, 1, 1'b1);

    // R8: redirect of next pointer.
    put_desc(32'h400, 32'hA000_0004, 32'hB000_0004, 32'h44, 32'h500);
    put_desc(32'h500, 32'hA000_0005, 32'hB000_0005, 32'h55, 32'h7F0);
    put_desc(32'h7F0, 32'hEEEE_0007, 32'hEEEE_0008, 32'h77, 32'h7F0);
    put_desc(32'h600, 32'hA000_0006, 32'hB000_0006, 32'h66, 32'h400);
    wrap_en = 1'b1; wrap_at = 32'h7F0; restart_at = 32'h600;
    push_exp(32'h400); push_exp(32'h500); push_exp(32'h600); push_exp(32'h400);
    run_chain(32'h400, 1, 4, 1, 1'b0);

    // R8: redirect disabled, the chain follows 0x7F0 literally.
    wrap_en = 1'b0;
    push_exp(32'h400); push_exp(32'h500); push_exp(32'h7F0);
    run_chain(32'h400, 1, 3, 0, 1'b0);

    // R5: stray completion while idle has no effect.
    loads = 0;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 idle xfer_done busy", 96'(busy), 96'd0);
    chk("R5 idle xfer_done loads", 96'(loads), 96'd0);
    chk("R9 no read while idle", 96'(stray_reads), 96'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout (all requirements) actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule